// File: doc/BRIEF.md
# NAND Sector Hamming Syndrome Corrector

This block decides whether a 512-byte NAND sector read back cleanly. It takes two 24-bit check words. One is the code stored in the spare area. The other is the code recomputed over the data as it streamed in. The block XORs the two into a syndrome, counts the set bits with a registered two-half adder tree, and classifies the outcome into one of four results: clean, one data bit to flip, damage confined to the stored code, or beyond repair. When a single bit must be flipped, the block reports its byte and bit position so a downstream stage can patch the buffer. Computing the parity and accessing the buffer happen elsewhere.

A 24-bit code holds twelve line/column parity levels. Bits [11:0] are the even-half parities and bits [23:12] are the odd-half parities. Bit k and bit 12+k both belong to the level of weight 2^k. Levels 0..2 address the bit within a byte and levels 3..11 address the byte. A full 2048-byte page is checked as four sectors in sequence. Sector i occupies bits [24i+23:24i] of each code input. The run halts at the first sector whose result cannot be repaired.

The controller has three states. IDLE waits for `start`. SYND registers the syndrome and the two half popcounts. CLASS sums the halves, classifies the result and emits the `done` pulse. The transitions are:
- IDLE→SYND when `start` is high.
- SYND→CLASS always.
- CLASS→SYND when more sectors remain and the result was repairable.
- CLASS→IDLE when the last sector is done or the result was fatal.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: After reset, `done` is low and `status`, `byte_idx`, `bit_idx`, `sector` and `last` are all zero.
- R2: A syndrome with zero set bits gives status 2'b00 (clean), with byte and bit indices zero.
- R3: A syndrome with exactly 12 set bits gives status 2'b01 (repairable). `bit_idx` = syndrome[14:12] and `byte_idx` = syndrome[23:15], where the syndrome is stored XOR computed.
- R4: A syndrome with exactly one set bit gives status 2'b10 (stored code damaged), and no position is reported.
- R5: Any other syndrome weight gives status 2'b11 (uncorrectable), except for the case in R6.
- R6: A stored code of 24'hFFFFFF together with a computed code of 24'h000000 (an erased sector) gives status 2'b00.
- R7: `done` is a one-cycle pulse. For the first sector, `done` is high in the cycle after the third rising edge, counting the edge that samples `start` as the first.
- R8: With `page_mode` high, sectors 0..NSEC-1 are checked in order. Successive `done` pulses are two cycles apart, and each pulse carries its sector number in `sector`. With `page_mode` low, only sector 0 is checked.
- R9: A result of 2'b10 or 2'b11 ends the run. No further `done` pulse follows until the next start. `last` is high on the final pulse of every run.
- R10: `start` is ignored while a run is in progress.
- R11: `byte_idx` and `bit_idx` are zero whenever `status` is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only in IDLE |
| page_mode | input | 1 | 1: check NSEC sectors, 0: check sector 0 only |
| stored_ecc | input | NSEC*24 | Codes read from the spare area, sector i at [24i+23:24i] |
| calc_ecc | input | NSEC*24 | Codes recomputed over the data, same packing |
| done | output | 1 | One-cycle result strobe per checked sector |
| status | output | 2 | 00 clean, 01 repairable, 10 code damaged, 11 uncorrectable |
| sector | output | clog2(NSEC) | Sector the result belongs to |
| byte_idx | output | 9 | Byte to patch when status is 01 |
| bit_idx | output | 3 | Bit to patch when status is 01 |
| last | output | 1 | High on the final result pulse of a run |

## Verification
The hardest condition to reach is the one that ends a page run early: a fatal result in the middle of a multi-sector page, after earlier sectors were repairable. The stimulus builds such pages deliberately by mixing clean, single-flip, single-code-bit and erased sectors. It checks that the pulses stop exactly at the fatal sector. Single-bit data errors are swept over all 4096 bit positions. Each syndrome is built arithmetically from the position: the odd half equals the address and the even half equals its complement. Starts issued while a run is in progress are checked to leave the result sequence unchanged.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FIXED  = 2'd1,
        ST_ECCERR = 2'd2,
        ST_UNCORR = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SYND  = 2'd1,
        S_CLASS = 2'd2
    } fix_state_e;

endpackage

// File: rtl/ecc_pop_count.sv
module ecc_pop_count #(
    parameter int W    = 12,
    parameter int CNTW = $clog2(W + 1)
) (
    input  logic [W-1:0]    bits,
    output logic [CNTW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CNTW'(bits[i]);
        end
    end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import ecc_fix_pkg::*;
#(
    parameter int LEVELS = 12,
    parameter int BITW   = 3,
    parameter int PW     = $clog2(2 * LEVELS + 1)
) (
    input  logic [PW-1:0]          pop,
    input  logic [2*LEVELS-1:0]    syn,
    input  logic                   erased,
    output ecc_status_e            status,
    output logic [LEVELS-BITW-1:0] byte_idx,
    output logic [BITW-1:0]        bit_idx
);
    always_comb begin
        byte_idx = '0;
        bit_idx  = '0;
        if (pop == '0) begin
            status = ST_CLEAN;
        end else if (pop == PW'(LEVELS)) begin
            status   = ST_FIXED;
            bit_idx  = syn[LEVELS+BITW-1:LEVELS];
            byte_idx = syn[2*LEVELS-1:LEVELS+BITW];
        end else if (pop == PW'(1)) begin
            status = ST_ECCERR;
        end else if (erased) begin
            status = ST_CLEAN;
        end else begin
            status = ST_UNCORR;
        end
    end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
    import ecc_fix_pkg::*;
#(
    parameter int NSEC   = 4,
    parameter int LEVELS = 12,
    parameter int BITW   = 3,
    parameter int SECW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     page_mode,
    input  logic [NSEC*2*LEVELS-1:0] stored_ecc,
    input  logic [NSEC*2*LEVELS-1:0] calc_ecc,
    output logic                     done,
    output logic [1:0]               status,
    output logic [SECW-1:0]          sector,
    output logic [LEVELS-BITW-1:0]   byte_idx,
    output logic [BITW-1:0]          bit_idx,
    output logic                     last
);
    localparam int CW  = 2 * LEVELS;
    localparam int GW  = NSEC * CW;
    localparam int HW  = $clog2(LEVELS + 1);
    localparam int PW  = $clog2(CW + 1);
    localparam int BYW = LEVELS - BITW;

    fix_state_e state_q, state_d;

    logic [GW-1:0]   grp_s_q, grp_c_q;
    logic [SECW-1:0] sec_q, last_sec_q;
    logic [CW-1:0]   syn_q;
    logic [HW-1:0]   half_q [2];
    logic            erased_q;

    logic [CW-1:0]   cur_s, cur_c, syn_w;
    logic [HW-1:0]   half_w [2];
    logic [PW-1:0]   pop_sum;
    ecc_status_e     cls_status;
    logic [BYW-1:0]  cls_byte;
    logic [BITW-1:0] cls_bit;
    logic            cls_fatal, cls_final;

    assign cur_s = grp_s_q[CW-1:0];
    assign cur_c = grp_c_q[CW-1:0];
    assign syn_w = cur_s ^ cur_c;

    // two half-width popcounts, registered, then summed: a 2-level tree
    for (genvar h = 0; h < 2; h++) begin : g_half
        ecc_pop_count #(.W(LEVELS), .CNTW(HW)) u_pop (
            .bits (syn_w[h*LEVELS +: LEVELS]),
            .cnt  (half_w[h])
        );
    end

    assign pop_sum = PW'(half_q[0]) + PW'(half_q[1]);

    ecc_classify #(.LEVELS(LEVELS), .BITW(BITW), .PW(PW)) u_cls (
        .pop      (pop_sum),
        .syn      (syn_q),
        .erased   (erased_q),
        .status   (cls_status),
        .byte_idx (cls_byte),
        .bit_idx  (cls_bit)
    );

    assign cls_fatal = cls_status[1];
    assign cls_final = cls_fatal || (sec_q == last_sec_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_SYND;
            S_SYND:  state_d = S_CLASS;
            S_CLASS: state_d = cls_final ? S_IDLE : S_SYND;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_s_q    <= '0;
            grp_c_q    <= '0;
            sec_q      <= '0;
            last_sec_q <= '0;
            syn_q      <= '0;
            half_q[0]  <= '0;
            half_q[1]  <= '0;
            erased_q   <= 1'b0;
            done       <= 1'b0;
            status     <= 2'b00;
            sector     <= '0;
            byte_idx   <= '0;
            bit_idx    <= '0;
            last       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        grp_s_q    <= stored_ecc;
                        grp_c_q    <= calc_ecc;
                        sec_q      <= '0;
                        last_sec_q <= page_mode ? SECW'(NSEC - 1) : '0;
                    end
                end
                S_SYND: begin
                    syn_q     <= syn_w;
                    half_q[0] <= half_w[0];
                    half_q[1] <= half_w[1];
                    erased_q  <= (&cur_s) && !(|cur_c);
                end
                S_CLASS: begin
                    done     <= 1'b1;
                    status   <= cls_status;
                    sector   <= sec_q;
                    byte_idx <= cls_byte;
                    bit_idx  <= cls_bit;
                    last     <= cls_final;
                    grp_s_q  <= grp_s_q >> CW;
                    grp_c_q  <= grp_c_q >> CW;
                    sec_q    <= sec_q + SECW'(1);
                end
                default: ;
            endcase
        end
    end

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == S_IDLE) |-> ##3 done);

    // R7
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !last) |-> ##2 done);

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last) |=> state_q == S_IDLE);

    // R11
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01) |-> (byte_idx == '0 && bit_idx == '0));

endmodule

// File: tb/sim_ecc_syndrome_fix.sv
module sim_ecc_syndrome_fix;
    localparam int NSEC = 4;
    localparam int CW   = 24;
    localparam int GW   = NSEC * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          page_mode = 1'b0;
    logic [GW-1:0] stored_ecc = '0;
    logic [GW-1:0] calc_ecc = '0;
    logic          done;
    logic [1:0]    status;
    logic [1:0]    sector;
    logic [8:0]    byte_idx;
    logic [2:0]    bit_idx;
    logic          last;

    int total = 0;
    int bad = 0;
    logic [31:0] rng = 32'h1badf00d;

    // 4 time units per period: 250 MHz at a 1 ns unit
    always #2 clk = ~clk;

    ecc_syndrome_fix #(.NSEC(NSEC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
        .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .done(done),
        .status(status), .sector(sector), .byte_idx(byte_idx),
        .bit_idx(bit_idx), .last(last)
    );

    int         nev;
    logic [1:0] ev_st [8];
    logic [8:0] ev_by [8];
    logic [2:0] ev_bi [8];
    logic [1:0] ev_sec [8];
    logic       ev_last [8];
    int         ev_t [8];

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic rand24(output logic [23:0] v);
        rng = next_rng(rng);
        v = rng[23:0];
    endtask

    // expected result from the requirement rules
    task automatic ref_cls(input logic [23:0] s, input logic [23:0] c,
                           output logic [1:0] st, output logic [8:0] by,
                           output logic [2:0] bi);
        logic [23:0] syn;
        int p;
        syn = s ^ c;
        p = $countones(syn);
        by = '0;
        bi = '0;
        if (p == 0)                                  st = 2'b00;
        else if (p == 12) begin st = 2'b01; bi = syn[14:12]; by = syn[23:15]; end
        else if (p == 1)                             st = 2'b10;
        else if (s == 24'hFFFFFF && c == 24'h0)      st = 2'b00;
        else                                         st = 2'b11;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(input bit pg, input logic [GW-1:0] s,
                       input logic [GW-1:0] c, input bit poke);
        @(negedge clk);
        page_mode  = pg;
        stored_ecc = s;
        calc_ecc   = c;
        start      = 1'b1;
        nev = 0;
        for (int k = 1; k <= 3 + 2 * NSEC + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (poke) begin
                    page_mode  = ~pg;
                    stored_ecc = ~s;
                end else begin
                    start = 1'b0;
                end
            end
            if (k == 2) start = 1'b0;
            if (done && nev < 8) begin
                ev_st[nev]   = status;
                ev_by[nev]   = byte_idx;
                ev_bi[nev]   = bit_idx;
                ev_sec[nev]  = sector;
                ev_last[nev] = last;
                ev_t[nev]    = k;
                nev++;
            end
        end
    endtask

    task automatic check_run(input bit pg, input logic [GW-1:0] s,
                             input logic [GW-1:0] c, input bit poke,
                             input string tag);
        int n, exp_n;
        bit stop;
        logic [1:0] st;
        logic [8:0] by;
        logic [2:0] bi;
        run(pg, s, c, poke);
        n = pg ? NSEC : 1;
        exp_n = 0;
        stop = 0;
        for (int i = 0; i < n && !stop; i++) begin
            ref_cls(s[CW*i +: CW], c[CW*i +: CW], st, by, bi);
            if (i < nev) begin
                chk(ev_st[i] == st, tag, "status", ev_st[i], st);
                chk(ev_by[i] == by, (st == 2'b01) ? "R3" : "R11", "byte_idx", ev_by[i], by);
                chk(ev_bi[i] == bi, (st == 2'b01) ? "R3" : "R11", "bit_idx", ev_bi[i], bi);
                chk(ev_t[i] == 3 + 2 * i, (i == 0) ? "R7" : "R8", "done cycle", ev_t[i], 3 + 2 * i);
                chk(ev_sec[i] == 2'(i), "R8", "sector", ev_sec[i], i);
                chk(ev_last[i] == (st[1] || i == n - 1), "R9", "last",
                    ev_last[i], (st[1] || i == n - 1));
            end
            exp_n++;
            if (st[1]) stop = 1;
        end
        chk(nev == exp_n, poke ? "R10" : "R9", "pulse count", nev, exp_n);
    endtask

    initial begin
        #(4 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] s, c, d;
        logic [GW-1:0] ps, pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(status == 2'b00, "R1", "status", status, 0);
        chk(byte_idx == '0 && bit_idx == '0, "R1", "indices", {byte_idx, bit_idx}, 0);
        chk(sector == '0 && last == 1'b0, "R1", "sector/last", {sector, last}, 0);

        // R2 matching codes
        for (int i = 0; i < 16; i++) begin
            rand24(s);
            check_run(0, GW'(s), GW'(s), 0, "R2");
        end

        // R3 every single data-bit position: odd half = address, even half = ~address
        for (int a = 0; a < 4096; a++) begin
            logic [11:0] ad;
            ad = 12'(a);
            rand24(s);
            c = s ^ {ad, ~ad};
            check_run(0, GW'(s), GW'(c), 0, "R3");
        end

        // R4 single flipped code bit
        for (int b = 0; b < 24; b++) begin
            rand24(s);
            check_run(0, GW'(s), GW'(s ^ (24'd1 << b)), 0, "R4");
        end

        // R5 random, plus weights 2, 11, 13, 24
        for (int i = 0; i < 200; i++) begin
            rand24(s);
            rand24(d);
            check_run(0, GW'(s), GW'(s ^ d), 0, "R5");
        end
        rand24(s);
        check_run(0, GW'(s), GW'(s ^ 24'h000003), 0, "R5");
        check_run(0, GW'(s), GW'(s ^ 24'h0007FF), 0, "R5");
        check_run(0, GW'(s), GW'(s ^ 24'h001FFF), 0, "R5");
        check_run(0, GW'(24'h123456), GW'(~24'h123456), 0, "R5");

        // R6 erased sector, and near-erased variants
        check_run(0, GW'(24'hFFFFFF), GW'(24'h0), 0, "R6");
        check_run(0, GW'(24'hFFFFFF), GW'(24'h000010), 0, "R5");
        check_run(1, {NSEC{24'hFFFFFF}}, '0, 0, "R6");

        // R8 full page: clean, fixable, erased, fixable
        ps = {24'h0A0B0C, 24'hFFFFFF, 24'h555555, 24'h13579B};
        pc = {24'h0A0B0C ^ {12'h5A5, ~12'h5A5}, 24'h0, 24'h555555 ^ {12'h001, ~12'h001}, 24'h13579B};
        check_run(1, ps, pc, 0, "R8");
        // R8 page_mode low checks sector 0 only
        check_run(0, ps, pc, 0, "R8");

        // R9 fatal in sector 1 stops the run; code damage in sector 2 also stops
        pc = {24'h0A0B0C, 24'h0, 24'h555555 ^ 24'h00000F, 24'h13579B ^ {12'h0FF, ~12'h0FF}};
        check_run(1, ps, pc, 0, "R9");
        pc = {24'h0A0B0C, 24'h0 ^ 24'h800000 ^ 24'hFFFFFF, 24'h555555, 24'h13579B};
        check_run(1, ps, pc, 0, "R9");

        // R10 start held with other data while busy
        rand24(s);
        check_run(0, GW'(s), GW'(s ^ {12'h321, ~12'h321}), 1, "R10");
        pc = {24'h0A0B0C, 24'h0, 24'h555555, 24'h13579B};
        check_run(1, ps, pc, 1, "R10");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule